// File: doc/BRIEF.md
# Programmable Time-Window Coincidence Flagger

The block watches the serial sample stream of one wire, with one sample taken each clock, and reports in which of eleven time windows a short pulse was seen. A reference strobe starts a measurement span. A divide-by-five counter groups the fine samples into coarse time units. The span runs for 66 coarse units, which is 330 samples. Each window is defined by a first and a last coarse unit, and it is flagged when a run of four consecutive 1 samples completes inside it.

When the span ends, the eleven flags are copied to the output register and a one-cycle valid strobe is raised. The accumulators are cleared when the next span starts. Software loads each window's bounds through a simple write port, which accepts writes only while no span is running. The write port also rejects any configuration in which the summed width of the enabled windows would exceed 43 coarse units.

Top module: `tw_flagger`

## Requirements
- R1: After reset, flags_o is 0, flags_valid_o is 0 and busy_o is 0. Every window is disabled (first=127, last=0), so no flag can be set until a window is written.
- R2: A ref_strobe_i seen while idle starts a span on the next clock. busy_o stays high for exactly 330 cycles. flags_valid_o is high for exactly one cycle, the cycle after the last sample of the span.
- R3: Samples are numbered n = 0..329, starting with the first cycle after the accepted strobe. Sample n belongs to coarse unit n/5 (integer division), so units run from 0 to 65.
- R4: A hit is a sample equal to 1 that is preceded by at least three 1 samples in the same span. Samples taken before or during the strobe cycle never count toward a run. A run of three ones produces no hit.
- R5: Window w is flagged when a hit occurs in a coarse unit u with first_w <= u <= last_w, inclusive at both ends. This includes a hit on the very last sample of the span.
- R6: A window with first > last, or with last > 65, is disabled. A disabled window is never flagged and counts zero toward the coverage sum.
- R7: A write (cfg_we_i=1) changes window cfg_sel_i only while busy_o is 0 and cfg_sel_i is below 11. Other writes have no effect.
- R8: A write is dropped if, once applied, the sum of (last-first+1) over all enabled windows would exceed 43 units. A sum of exactly 43 is accepted.
- R9: A ref_strobe_i seen while busy is ignored. The flag accumulators are cleared at each span start. flags_o holds its value until the next span ends.
- R10: Bit w of flags_o belongs to the window written with cfg_sel_i = w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Serial wire sample |
| ref_strobe_i | input | 1 | Span start strobe |
| cfg_we_i | input | 1 | Window write enable |
| cfg_sel_i | input | 4 | Window index to write |
| cfg_first_i | input | 7 | First coarse unit of the window |
| cfg_last_i | input | 7 | Last coarse unit of the window |
| busy_o | output | 1 | Span in progress |
| flags_o | output | 11 | Latched window flags of the last span |
| flags_valid_o | output | 1 | One-cycle pulse when flags_o is updated |

## Verification
The bench places eleven windows three units wide, six units apart, and sweeps a single four-sample burst across every even start position of the span. This separates a correct coarse index and inclusive bounds from off-by-one errors in the unit counter or the window compare. Three-sample runs, ones held across the strobe cycle and an all-ones stream separate the run-length rule from a plain level detector. Windows that are disabled, that sit on the last unit, that hit the coverage limit, or that are written or strobed mid-span separate the gating rules from each other.

// File: rtl/tw_pkg.sv
package tw_pkg;
  parameter int unsigned TW_IDX_W = 7;

  typedef struct packed {
    logic [TW_IDX_W-1:0] first;
    logic [TW_IDX_W-1:0] last;
  } win_cfg_t;
endpackage

// File: rtl/tw_timebase.sv
module tw_timebase #(
  parameter int unsigned FINE_PER_UNIT = 5,
  parameter int unsigned SPAN_UNITS    = 66
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ref_strobe_i,
  output logic                         start_o,
  output logic                         active_o,
  output logic                         last_o,
  output logic [tw_pkg::TW_IDX_W-1:0]  unit_o
);
  localparam int unsigned FW = (FINE_PER_UNIT > 1) ? $clog2(FINE_PER_UNIT) : 1;
  localparam int unsigned UW = tw_pkg::TW_IDX_W;
  localparam logic [FW-1:0] FINE_MAX = FW'(FINE_PER_UNIT - 1);
  localparam logic [UW-1:0] UNIT_MAX = UW'(SPAN_UNITS - 1);

  logic          active_q, active_d;
  logic [FW-1:0] fine_q, fine_d;
  logic [UW-1:0] unit_q, unit_d;
  logic          fine_wrap;

  assign start_o   = ref_strobe_i & ~active_q;
  assign fine_wrap = (fine_q == FINE_MAX);
  assign last_o    = active_q & fine_wrap & (unit_q == UNIT_MAX);
  assign active_o  = active_q;
  assign unit_o    = unit_q;

  always_comb begin
    active_d = active_q;
    fine_d   = fine_q;
    unit_d   = unit_q;
    if (start_o) begin
      active_d = 1'b1;
      fine_d   = '0;
      unit_d   = '0;
    end else if (active_q) begin
      if (fine_wrap) begin
        fine_d = '0;
        if (unit_q == UNIT_MAX) begin
          active_d = 1'b0;
        end else begin
          unit_d = unit_q + 1'b1;
        end
      end else begin
        fine_d = fine_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fine_q   <= '0;
      unit_q   <= '0;
    end else begin
      active_q <= active_d;
      fine_q   <= fine_d;
      unit_q   <= unit_d;
    end
  end

  AST_FINE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fine_q <= FINE_MAX); // R3
  AST_SPAN_ENDS_AT_LAST_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> ($past(unit_q) == UNIT_MAX)); // R2
  AST_UNIT_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (unit_q <= UNIT_MAX)); // R3
endmodule

// File: rtl/tw_run_detect.sv
module tw_run_detect #(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic active_i,
  input  logic sample_i,
  output logic hit_o
);
  localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign hit_o = active_i & sample_i & (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = '0;
    if (!start_i && active_i && sample_i) begin
      cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (RUN_LEN == 4) begin : g_run4_chk
      AST_HIT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ($past(sample_i, 1) && $past(sample_i, 2) && $past(sample_i, 3))); // R4
    end
  endgenerate
  AST_HIT_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(active_i)); // R4
endmodule

// File: rtl/tw_window_bank.sv
module tw_window_bank #(
  parameter int unsigned NUM_WIN    = 11,
  parameter int unsigned SPAN_UNITS = 66,
  parameter int unsigned MAX_COVER  = 43,
  parameter int unsigned SEL_W      = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         active_i,
  input  logic                         hit_i,
  input  logic [tw_pkg::TW_IDX_W-1:0]  unit_i,
  input  logic                         cfg_we_i,
  input  logic [SEL_W-1:0]             cfg_sel_i,
  input  logic [tw_pkg::TW_IDX_W-1:0]  cfg_first_i,
  input  logic [tw_pkg::TW_IDX_W-1:0]  cfg_last_i,
  output logic [NUM_WIN-1:0]           hits_o,
  output logic [NUM_WIN-1:0]           acc_o
);
  import tw_pkg::*;
  localparam int unsigned UW    = TW_IDX_W;
  localparam int unsigned SUM_W = $clog2(NUM_WIN * (SPAN_UNITS + 1) + 1);
  localparam logic [UW-1:0]    SPAN_LIM  = UW'(SPAN_UNITS);
  localparam logic [SUM_W-1:0] COVER_LIM = SUM_W'(MAX_COVER);

  win_cfg_t             cfg_q [NUM_WIN];
  logic [NUM_WIN-1:0]   en;
  logic [SUM_W-1:0]     width [NUM_WIN];
  logic [NUM_WIN-1:0]   acc_q, acc_d;
  logic                 cand_en;
  logic [SUM_W-1:0]     cand_width;
  logic [SUM_W-1:0]     cand_sum, cur_sum;
  logic                 wr_ok;

  assign cand_en    = (cfg_first_i <= cfg_last_i) && (cfg_last_i < SPAN_LIM);
  assign cand_width = cand_en ? SUM_W'({1'b0, cfg_last_i} - {1'b0, cfg_first_i} + 1'b1) : '0;

  always_comb begin
    cand_sum = '0;
    cur_sum  = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      cur_sum  = cur_sum + width[w];
      cand_sum = cand_sum + ((w == int'(cfg_sel_i)) ? cand_width : width[w]);
    end
  end

  assign wr_ok = cfg_we_i & ~active_i & (int'(cfg_sel_i) < NUM_WIN) & (cand_sum <= COVER_LIM);

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      win_cfg_t cfg_d;
      assign en[w]    = (cfg_q[w].first <= cfg_q[w].last) && (cfg_q[w].last < SPAN_LIM);
      assign width[w] = en[w] ? SUM_W'({1'b0, cfg_q[w].last} - {1'b0, cfg_q[w].first} + 1'b1) : '0;
      assign hits_o[w] = hit_i & en[w] & (unit_i >= cfg_q[w].first) & (unit_i <= cfg_q[w].last);

      always_comb begin
        cfg_d = cfg_q[w];
        if (wr_ok && (int'(cfg_sel_i) == w)) begin
          cfg_d.first = cfg_first_i;
          cfg_d.last  = cfg_last_i;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q[w].first <= '1;
          cfg_q[w].last  <= '0;
        end else begin
          cfg_q[w] <= cfg_d;
        end
      end

      AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |=> $stable(cfg_q[w])); // R7
    end
  endgenerate

  always_comb begin
    acc_d = acc_q;
    if (start_i)       acc_d = '0;
    else if (active_i) acc_d = acc_q | hits_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  AST_COVER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cur_sum <= COVER_LIM); // R8
  AST_FLAGS_ONLY_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !start_i) |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R5
  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hits_o & ~en) == '0); // R6
endmodule

// File: rtl/tw_flagger.sv
module tw_flagger #(
  parameter int unsigned NUM_WIN       = 11,
  parameter int unsigned SPAN_UNITS    = 66,
  parameter int unsigned FINE_PER_UNIT = 5,
  parameter int unsigned RUN_LEN       = 4,
  parameter int unsigned MAX_COVER     = 43,
  parameter int unsigned SEL_W         = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sample_i,
  input  logic                         ref_strobe_i,
  input  logic                         cfg_we_i,
  input  logic [SEL_W-1:0]             cfg_sel_i,
  input  logic [tw_pkg::TW_IDX_W-1:0]  cfg_first_i,
  input  logic [tw_pkg::TW_IDX_W-1:0]  cfg_last_i,
  output logic                         busy_o,
  output logic [NUM_WIN-1:0]           flags_o,
  output logic                         flags_valid_o
);
  logic                         start, active, last, hit;
  logic [tw_pkg::TW_IDX_W-1:0]  unit;
  logic [NUM_WIN-1:0]           hits, acc;
  logic [NUM_WIN-1:0]           flags_q, flags_d;
  logic                         valid_q;

  tw_timebase #(.FINE_PER_UNIT(FINE_PER_UNIT), .SPAN_UNITS(SPAN_UNITS)) u_tb (
    .clk(clk), .rst_n(rst_n), .ref_strobe_i(ref_strobe_i),
    .start_o(start), .active_o(active), .last_o(last), .unit_o(unit)
  );

  tw_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst_n(rst_n), .start_i(start), .active_i(active),
    .sample_i(sample_i), .hit_o(hit)
  );

  tw_window_bank #(.NUM_WIN(NUM_WIN), .SPAN_UNITS(SPAN_UNITS),
                   .MAX_COVER(MAX_COVER), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .start_i(start), .active_i(active),
    .hit_i(hit), .unit_i(unit), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_first_i(cfg_first_i), .cfg_last_i(cfg_last_i),
    .hits_o(hits), .acc_o(acc)
  );

  always_comb begin
    flags_d = flags_q;
    if (last) flags_d = acc | hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      valid_q <= 1'b0;
    end else begin
      flags_q <= flags_d;
      valid_q <= last;
    end
  end

  assign busy_o        = active;
  assign flags_o       = flags_q;
  assign flags_valid_o = valid_q;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flags_valid_o |=> !flags_valid_o); // R2
  AST_VALID_AFTER_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    flags_valid_o |-> ($past(busy_o) && !busy_o)); // R2
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_valid_o |-> $stable(flags_o)); // R9
endmodule

// File: tb/tw_flagger_tb.sv
module tw_flagger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 11;
  localparam int NS = 330;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample = 1'b0, strobe = 1'b0, we = 1'b0;
  logic [3:0] sel = '0;
  logic [6:0] first = '0, last = '0;
  logic busy, valid;
  logic [NW-1:0] flags;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  int m_first [NW];
  int m_last  [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_flagger dut_i (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .ref_strobe_i(strobe),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_first_i(first), .cfg_last_i(last),
    .busy_o(busy), .flags_o(flags), .flags_valid_o(valid)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_en(int f, int l);
    return (f <= l) && (l < 66);
  endfunction

  function automatic int m_sum(int ws, int f, int l);
    int s = 0;
    for (int w = 0; w < NW; w++) begin
      int ff = (w == ws) ? f : m_first[w];
      int ll = (w == ws) ? l : m_last[w];
      if (m_en(ff, ll)) s += ll - ff + 1;
    end
    return s;
  endfunction

  function automatic logic [NW-1:0] m_flags(bit [NS-1:0] pat);
    logic [NW-1:0] r = '0;
    int run = 0;
    for (int k = 0; k < NS; k++) begin
      if (pat[k]) begin
        if (run >= 3) begin
          for (int w = 0; w < NW; w++)
            if (m_en(m_first[w], m_last[w]) && (k/5) >= m_first[w] && (k/5) <= m_last[w])
              r[w] = 1'b1;
        end
        run++;
      end else run = 0;
    end
    return r;
  endfunction

  // idle write; model applies the acceptance rules of R7 and R8
  task automatic cfg_wr(input int s, input int f, input int l);
    sel = 4'(s); first = 7'(f); last = 7'(l); we = 1'b1;
    if (s < NW && m_sum(s, f, l) <= 43) begin
      m_first[s] = f; m_last[s] = l;
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic run_span(input bit [NS-1:0] pat, input bit pre_one, input int wr_at,
                          input int ws, input int wf, input int wl, input int strb_at,
                          input string req);
    logic [NW-1:0] exp = m_flags(pat);
    sample = pre_one;
    repeat (3) @(negedge clk);
    strobe = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NS; k++) begin
      strobe = (k == strb_at);
      sample = pat[k];
      we     = (k == wr_at);
      sel = 4'(ws); first = 7'(wf); last = 7'(wl);
      if (k == 0)      chk("R2 busy at span start", busy, 1);
      if (k == NS - 1) chk("R2 busy on last sample", busy, 1);
      if (k == NS - 1) chk("R2 no early valid", valid, 0);
      @(negedge clk);
    end
    strobe = 1'b0; sample = 1'b0; we = 1'b0;
    chk({req, " valid"}, valid, 1);
    chk({req, " flags"}, flags, exp);
    chk("R2 busy drops", busy, 0);
    @(negedge clk);
    chk("R2 valid one cycle", valid, 0);
    chk("R9 flags held", flags, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit [NS-1:0] p;
    for (int w = 0; w < NW; w++) begin m_first[w] = 127; m_last[w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", flags, 0);
    chk("R1 valid", valid, 0);
    chk("R1 busy", busy, 0);
    run_span('1, 0, -1, 0, 0, 0, -1, "R1 all disabled");

    // R3 R5 R10: eleven 3-unit windows, sweep a 4-sample burst
    for (int w = 0; w < NW; w++) cfg_wr(w, 6*w, 6*w + 2);
    for (int q = 0; q + 3 < NS; q += 2) begin
      p = '0;
      p[q +: 4] = 4'hF;
      run_span(p, 0, -1, 0, 0, 0, -1, "R3 R5 R10 burst sweep");
    end

    // R4: runs of three never hit
    p = '0;
    for (int k = 0; k < NS; k++) p[k] = (k % 4) != 3;
    run_span(p, 0, -1, 0, 0, 0, -1, "R4 three-runs");
    // R4: ones before/at the strobe do not extend a run
    p = '0; p[2:0] = 3'b111;
    run_span(p, 1, -1, 0, 0, 0, -1, "R4 span-local run");
    // R5: all ones flags every window
    run_span('1, 0, -1, 0, 0, 0, -1, "R5 all ones");

    // R6: disabled windows and last-unit window
    cfg_wr(3, 20, 19);
    cfg_wr(4, 60, 66);
    cfg_wr(5, 65, 65);
    run_span('1, 0, -1, 0, 0, 0, -1, "R6 disabled windows");
    p = '0; p[329:326] = 4'hF;
    run_span(p, 0, -1, 0, 0, 0, -1, "R6 R5 last sample hit");

    // R8: sum exactly 43 accepted, above dropped
    cfg_wr(0, 0, 20);
    cfg_wr(1, 6, 10);
    p = '0; p[97:94] = 4'hF; p[48:45] = 4'hF;
    run_span(p, 0, -1, 0, 0, 0, -1, "R8 coverage limit");

    // R7 R9: write and strobe while busy are ignored
    p = '0; p[213:210] = 4'hF;
    run_span(p, 0, 100, 7, 0, 0, 200, "R7 R9 busy write/strobe");
    run_span('1, 0, -1, 0, 0, 0, -1, "R7 window kept after busy write");
    // R7: out-of-range select has no effect
    cfg_wr(11, 0, 0);
    cfg_wr(15, 0, 0);
    run_span('1, 0, -1, 0, 0, 0, -1, "R7 bad select");
    // R9: fresh result per span
    run_span('0, 0, -1, 0, 0, 0, -1, "R9 cleared per span");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule